// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block generates four independent pulse-width-modulated outputs from a single input clock. Each channel has a 14-bit prescaler that divides the clock into ticks. A 16-bit period count and a 16-bit high-time count are measured in those ticks, so the output repeats every (prescale+1)×period clocks and is high for the first (prescale+1)×duty clocks of each repetition. A single master enable gates every channel. Each channel also has its own enable, and that enable still applies while the master enable is set.

Software configures the block through a synchronous register port with a word address, write data, a write strobe and combinational read data. Every channel has a 16-byte window. The master enable lives in one further word at the top of the address space. New settings written while a channel runs take effect at the next period boundary, so the output never shows a clipped or stretched pulse.

Top module: `pwm_bank`

## Requirements
- R1: Channel n's registers start at byte address n×0x10. Within a window, offset 0x0 is control, with bit 0 as the channel enable and bits 15:2 as the prescale. Offset 0x4 is the high-time count in bits 15:0. Offset 0x8 is the period count in bits 15:0. The master enable is bit 0 of address 0x3C. Each mapped register reads back what was last written to its fields.
- R2: Reserved bits read as zero. This covers control bit 1, control bits 31:16, count bits 31:16 and master bits 31:1. Addresses outside the map, including those not aligned to a word, read as zero, and writes to them change no register.
- R3: While the master enable is clear, every output is low.
- R4: Clearing a channel enable forces that output low from the cycle after the write. The channel's counters return to zero, so a later enable starts a fresh period.
- R5: A running channel's output period is (prescale+1)×period clock cycles.
- R6: The output is high for (prescale+1)×duty cycles, starting at the beginning of each period.
- R7: When duty ≥ period, the output stays high continuously.
- R8: Duty, period and prescale values written while a channel runs take effect only at the end of the current period.
- R9: When a channel becomes active, whether through its own enable or the master enable, it loads the current register values. Its output stays low in the cycle after the enabling write and rises in the cycle after that.
- R10: After reset, all registers read zero and all outputs are low.
- R11: Channels run independently; one channel's settings do not alter another's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and counters |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Byte address of the register access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe; the write takes effect at the rising edge |
| rdata | output | 32 | Read data for addr, combinational |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The hardest case to reach is a settings change that lands in the middle of a running period. Proving deferral means the write must fall inside a known high phase, and the next two periods must then be measured separately. The bench keeps a monitor on each output that records the high length and the period length at every rising edge. It waits for a rise, issues the writes within the following high phase, and then checks that one full period keeps the old lengths before the new ones appear. Counter clearing on disable is reached in a similar way: a channel is disabled part-way through a period, then re-enabled, and the first pulse must have full length.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int DATA_W   = 32;
  localparam int PRE_W    = 14;
  localparam int CNT_W    = 16;
  localparam int PRE_LSB  = 2;
  localparam int WIN_BITS = 4;

  localparam logic [WIN_BITS-1:0] OFF_CTRL   = 4'h0;
  localparam logic [WIN_BITS-1:0] OFF_DUTY   = 4'h4;
  localparam logic [WIN_BITS-1:0] OFF_PER    = 4'h8;
  localparam logic [WIN_BITS-1:0] OFF_MASTER = 4'hC;

  typedef enum logic [1:0] {FLD_CTRL, FLD_DUTY, FLD_PER, FLD_NONE} fld_e;

  typedef struct packed {
    logic             en;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] dc;
    logic [CNT_W-1:0] pv;
  } chan_cfg_t;

  function automatic fld_e decode_fld(input logic [WIN_BITS-1:0] off);
    case (off)
      OFF_CTRL: return FLD_CTRL;
      OFF_DUTY: return FLD_DUTY;
      OFF_PER:  return FLD_PER;
      default:  return FLD_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic en, input logic [PRE_W-1:0] pre);
    logic [DATA_W-1:0] v;
    v = '0;
    v[0] = en;
    v[PRE_LSB +: PRE_W] = pre;
    return v;
  endfunction

  // Final tick of a period: tick+1 has reached the period count.
  function automatic logic is_last_tick(input logic [CNT_W-1:0] tick, input logic [CNT_W-1:0] pv);
    return ({1'b0, tick} + (CNT_W+1)'(1)) >= {1'b0, pv};
  endfunction

  function automatic logic in_high(input logic [CNT_W-1:0] tick, input logic [CNT_W-1:0] dc);
    return tick < dc;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    we,
  output logic [DATA_W-1:0]       rdata,
  output chan_cfg_t [NCH-1:0]     cfg_o,
  output logic                    master_o
);
  localparam int IDX_W = ADDR_W - WIN_BITS;
  localparam logic [ADDR_W-1:0] MASTER_ADDR = {{IDX_W{1'b1}}, OFF_MASTER};

  logic [IDX_W-1:0]    idx;
  logic [WIN_BITS-1:0] off;
  fld_e                fld;
  logic                ch_hit, master_hit;
  logic                wr_chan, wr_master, wr_ignored;
  chan_cfg_t [NCH-1:0] cfg_q;
  logic                master_q;
  wire                 unused_wbits = ^{wdata[DATA_W-1:CNT_W], wdata[1]};

  assign idx        = addr[ADDR_W-1:WIN_BITS];
  assign off        = addr[WIN_BITS-1:0];
  assign fld        = decode_fld(off);
  assign ch_hit     = (int'(idx) < NCH) && (fld != FLD_NONE);
  assign master_hit = (addr == MASTER_ADDR);
  assign wr_chan    = we && ch_hit;
  assign wr_master  = we && master_hit;
  assign wr_ignored = we && !ch_hit && !master_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      master_q <= 1'b0;
    end else begin
      if (wr_master) master_q <= wdata[0];
      for (int i = 0; i < NCH; i++) begin
        if (wr_chan && int'(idx) == i) begin
          case (fld)
            FLD_CTRL: begin
              cfg_q[i].en  <= wdata[0];
              cfg_q[i].pre <= wdata[PRE_LSB +: PRE_W];
            end
            FLD_DUTY: cfg_q[i].dc <= wdata[CNT_W-1:0];
            FLD_PER:  cfg_q[i].pv <= wdata[CNT_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (master_hit) begin
      rdata[0] = master_q;
    end else if (ch_hit) begin
      for (int i = 0; i < NCH; i++) begin
        if (int'(idx) == i) begin
          case (fld)
            FLD_CTRL: rdata = pack_ctrl(cfg_q[i].en, cfg_q[i].pre);
            FLD_DUTY: rdata[CNT_W-1:0] = cfg_q[i].dc;
            FLD_PER:  rdata[CNT_W-1:0] = cfg_q[i].pv;
            default: ;
          endcase
        end
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign master_o = master_q;

  a_r2_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> ($stable(cfg_q) && $stable(master_q)));

  a_r1_master_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_master |=> (master_q == $past(wdata[0])));
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] dc_i,
  input  logic [CNT_W-1:0] pv_i,
  output logic             pwm_o
);
  logic             run_q;
  logic [PRE_W-1:0] pre_cnt, act_pre;
  logic [CNT_W-1:0] tick_cnt, act_dc, act_pv;
  logic             tick_end, last_tick, period_end;

  assign tick_end   = (pre_cnt == act_pre);
  assign last_tick  = is_last_tick(tick_cnt, act_pv);
  assign period_end = run_q && en_i && tick_end && last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      pre_cnt  <= '0;
      tick_cnt <= '0;
      act_pre  <= '0;
      act_dc   <= '0;
      act_pv   <= '0;
    end else if (!en_i || !run_q) begin
      // idle or first active cycle: counters at zero, settings tracked
      run_q    <= en_i;
      pre_cnt  <= '0;
      tick_cnt <= '0;
      act_pre  <= pre_i;
      act_dc   <= dc_i;
      act_pv   <= pv_i;
    end else if (tick_end) begin
      pre_cnt <= '0;
      if (last_tick) begin
        tick_cnt <= '0;
        act_pre  <= pre_i;
        act_dc   <= dc_i;
        act_pv   <= pv_i;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign pwm_o = run_q && en_i && in_high(tick_cnt, act_dc);

  a_r4_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pre_cnt == '0 && tick_cnt == '0 && !pwm_o));

  a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_i && !period_end) |=>
      ($stable(act_dc) && $stable(act_pv) && $stable(act_pre)));

  a_r5_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pre_cnt <= act_pre));

  a_r6_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> (tick_cnt == '0 && pre_cnt == '0));

  a_r7_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_i && act_pv != '0 && act_dc >= act_pv) |-> pwm_o);
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    pwm_out
);
  chan_cfg_t [NCH-1:0] cfg;
  logic                master_en;
  logic [NCH-1:0]      chan_active;

  pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .we       (we),
    .rdata    (rdata),
    .cfg_o    (cfg),
    .master_o (master_en)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign chan_active[g] = master_en && cfg[g].en;
    pwm_channel u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (chan_active[g]),
      .pre_i (cfg[g].pre),
      .dc_i  (cfg[g].dc),
      .pv_i  (cfg[g].pv),
      .pwm_o (pwm_out[g])
    );
  end

  a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (pwm_out == '0));
endmodule

// File: tb/sim_pwm_bank.sv
`timescale 1ns/1ps
module sim_pwm_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;
  int checks = 0;
  int errors = 0;

  pwm_bank u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
               .rdata(rdata), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  // per-channel waveform monitor, sampled at falling edges
  int rises[4], hi_len[4], per_len[4], cur_hi[4], cur_per[4];
  logic prev_o[4];
  initial for (int c = 0; c < 4; c++) begin
    rises[c] = 0; hi_len[c] = 0; per_len[c] = 0; cur_hi[c] = 0; cur_per[c] = 0; prev_o[c] = 1'b0;
  end
  always @(negedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (pwm_out[c] && !prev_o[c]) begin
        per_len[c] = cur_per[c]; cur_per[c] = 1; rises[c]++;
      end else cur_per[c]++;
      if (pwm_out[c]) cur_hi[c]++;
      else if (prev_o[c]) begin hi_len[c] = cur_hi[c]; cur_hi[c] = 0; end
      prev_o[c] = pwm_out[c];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic en, input logic [13:0] pre);
    return {16'h0, pre, 1'b0, en};
  endfunction

  function automatic logic [5:0] ra(input int ch, input logic [3:0] off);
    return {ch[1:0], off};
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_rises(input int ch, input int n);
    int start;
    start = rises[ch];
    for (int k = 0; k < 5000 && rises[ch] < start + n; k++) begin @(negedge clk); #1; end
  endtask

  task automatic count_level(input int ch, input logic lvl, input int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); #1; if (pwm_out[ch] == lvl) hits++; end
  endtask

  task automatic first_pulse(input int ch, output int len);
    len = 0;
    for (int k = 0; k < 2000 && !pwm_out[ch]; k++) begin @(negedge clk); #1; end
    for (int k = 0; k < 2000 && pwm_out[ch]; k++) begin len++; @(negedge clk); #1; end
  endtask

  task automatic t_reset;
    for (int c = 0; c < 4; c++) begin
      rdchk("R10 ctrl", ra(c, 4'h0), 0);
      rdchk("R10 duty", ra(c, 4'h4), 0);
      rdchk("R10 period", ra(c, 4'h8), 0);
    end
    rdchk("R10 master", 6'h3C, 0);
    chk("R10 outputs", {28'h0, pwm_out}, 0);
  endtask

  task automatic t_regmap;
    wr(ra(2, 4'h0), 32'hFFFF_FFFF);
    rdchk("R2 ctrl reserved bits", ra(2, 4'h0), 32'h0000_FFFD);
    wr(ra(1, 4'h4), 32'hABCD_1234);
    rdchk("R1 duty readback", ra(1, 4'h4), 32'h0000_1234);
    wr(ra(3, 4'h8), 32'h0000_BEEF);
    rdchk("R1 period readback", ra(3, 4'h8), 32'h0000_BEEF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rdchk("R1 master readback", 6'h3C, 32'h1);
    wr(6'h3C, 0);
    wr(ra(2, 4'h0), ctl(1'b0, 14'h0));
    rdchk("R1 ctrl cleared", ra(2, 4'h0), 0);
    wr(ra(1, 4'h4), 0);
    wr(ra(3, 4'h8), 0);
  endtask

  task automatic t_unmapped;
    wr(ra(0, 4'h4), 32'h55);
    wr(ra(0, 4'h5), 32'hFFFF_FFFF);
    wr(ra(0, 4'hC), 32'hFFFF_FFFF);
    wr(ra(1, 4'h1), 32'hFFFF_FFFF);
    rdchk("R2 duty untouched", ra(0, 4'h4), 32'h55);
    rdchk("R2 ctrl untouched", ra(1, 4'h0), 0);
    rdchk("R2 read 0x0C", ra(0, 4'hC), 0);
    rdchk("R2 read 0x05", ra(0, 4'h5), 0);
    rdchk("R2 read 0x2C", ra(2, 4'hC), 0);
  endtask

  task automatic t_master_basic;
    int h;
    wr(ra(0, 4'h4), 3);
    wr(ra(0, 4'h8), 8);
    wr(ra(0, 4'h0), ctl(1'b1, 14'd0));
    count_level(0, 1'b0, 40, h);
    chk("R3 gated low", h, 40);
    wr(6'h3C, 1);
    #1 chk("R9 low after enable", pwm_out[0], 0);
    @(negedge clk); #1 chk("R9 high next cycle", pwm_out[0], 1);
    wait_rises(0, 2);
    chk("R6 high 3", hi_len[0], 3);
    chk("R5 period 8", per_len[0], 8);
  endtask

  task automatic t_prescale;
    wr(ra(1, 4'h4), 2);
    wr(ra(1, 4'h8), 5);
    wr(ra(1, 4'h0), ctl(1'b1, 14'd2));
    wait_rises(1, 2);
    chk("R6 prescaled high", hi_len[1], 6);
    chk("R5 prescaled period", per_len[1], 15);
    wait_rises(0, 1); wait_rises(0, 1);
    chk("R11 ch0 high kept", hi_len[0], 3);
    chk("R11 ch0 period kept", per_len[0], 8);
  endtask

  task automatic t_full_high;
    int h;
    wr(ra(2, 4'h4), 4);
    wr(ra(2, 4'h8), 4);
    wr(ra(2, 4'h0), ctl(1'b1, 14'd1));
    @(negedge clk);
    count_level(2, 1'b1, 40, h);
    chk("R7 duty equals period", h, 40);
    wr(ra(2, 4'h4), 9);
    count_level(2, 1'b1, 40, h);
    chk("R7 duty above period", h, 40);
  endtask

  task automatic t_disable;
    int h;
    wr(ra(2, 4'h0), ctl(1'b0, 14'd1));
    #1 chk("R4 low after disable", pwm_out[2], 0);
    count_level(2, 1'b0, 20, h);
    chk("R4 stays low", h, 20);
    repeat (4) @(negedge clk);
    wr(ra(1, 4'h0), ctl(1'b0, 14'd2));
    #1 chk("R4 ch1 low", pwm_out[1], 0);
    repeat (3) @(negedge clk);
    wr(ra(1, 4'h0), ctl(1'b1, 14'd2));
    first_pulse(1, h);
    chk("R4 fresh first pulse", h, 6);
  endtask

  task automatic t_update;
    wait_rises(0, 1);
    wr(ra(0, 4'h4), 1);
    wr(ra(0, 4'h8), 12);
    wait_rises(0, 1);
    chk("R8 old high kept", hi_len[0], 3);
    chk("R8 old period kept", per_len[0], 8);
    wait_rises(0, 1);
    chk("R8 new high", hi_len[0], 1);
    chk("R8 new period", per_len[0], 12);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regmap;
    t_unmapped;
    t_master_basic;
    t_prescale;
    t_full_high;
    t_disable;
    t_update;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule